// File: doc/BRIEF.md
# Indexed Load/Store Address Unit

This unit executes one immediate-offset load/store-register instruction at a time. It accepts a 32-bit instruction word and reads the base register through a register-file read port. When the base field is 31 it uses the stack pointer value instead. It also reads the register that a store will send. From these it forms the access address in one of three addressing classes: scaled unsigned offset, pre-index or post-index. It then issues a single-beat memory request and holds it until the memory grants it.

When the memory response arrives, the unit does two things in that same cycle. For a load, it writes the returned data, sign- or zero-extended to a 32-bit or 64-bit destination, to the destination write port. When writeback applies, it sends the updated base address on a separate base-write port, marked for the stack pointer or for a general register. Encodings with no defined meaning and stack-pointer bases that are not aligned are rejected before any memory traffic. Each rejection gives a one-cycle fault pulse.

The controller has four states. ST_IDLE accepts work. ST_REQ presents the request. ST_RESP waits for the response. ST_FAULT drives a fault pulse. The transitions are as follows. T_ACCEPT goes ST_IDLE→ST_REQ on a valid legal word. T_REJECT goes ST_IDLE→ST_FAULT on an undefined word or a misaligned stack pointer. T_GRANT goes ST_REQ→ST_RESP when the memory grants. T_RETIRE goes ST_RESP→ST_IDLE when the response arrives. T_RECOVER goes ST_FAULT→ST_IDLE after one cycle.

Top module: `ldst_agu`

## Requirements
- R1: With word bit 24 = 1 (unsigned-offset class), the access address is base + (bits 21:10 zero-extended, shifted left by the size field in bits 31:30), and no base write ever occurs.
- R2: With bit 24 = 0, bit 21 = 0 and bits 11:10 = 11 (pre-index), the access address is base + sign-extended bits 20:12, and the same sum is written back to the base.
- R3: With bit 24 = 0, bit 21 = 0 and bits 11:10 = 01 (post-index), the access uses the unmodified base, and base + sign-extended bits 20:12 is written back.
- R4: A base field (bits 9:5) of 31 selects the stack-pointer input, and writeback is then flagged for the stack pointer. If the low 4 bits of the stack pointer are not all zero, a one-cycle alignment-fault pulse is given instead of any request or write.
- R5: With opc (bits 23:22) = 1x the load is sign-extended from 8<<size bits. opc bit 0 = 1 yields a 32-bit result with bits 63:32 zero; opc bit 0 = 0 yields a 64-bit result.
- R6: opc = 01 is a zero-extending load, and opc = 00 is a store that drives the write flag, size = bits 31:30 and the Rt register value. The destination is 64-bit only when size = 11; otherwise bits 63:32 are zero.
- R7: An undefined-instruction pulse lasting one cycle is given, with no request and no write, in any of these cases: bits 29:25 are not 11100; the class bits are none of the forms above; opc = 1x with size = 11; or opc = 11 with size = 10.
- R8: A load with writeback whose base and destination fields (bits 9:5, bits 4:0) are equal and not 31 performs the destination write and suppresses the base write. A store in the same case sends the register's original value.
- R9: A load whose destination field is 31 performs no destination write.
- R10: After reset the unit is ready and idle. From acceptance until the response it is not ready. The request, once raised, stays up with a stable address until granted.
- R11: The destination write and the base write happen only in the cycle in which the memory response is valid, and both occur in that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word is valid |
| ins_word | input | 32 | Instruction word |
| ins_ready | output | 1 | Unit idle, word accepted when valid |
| base_idx | output | 5 | Register-file read index for the base |
| base_val | input | 64 | Base register value |
| src_idx | output | 5 | Register-file read index for store data |
| src_val | input | 64 | Store data register value |
| sp_val | input | 64 | Stack pointer value |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Access address |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_size | output | 2 | Access size, log2 bytes |
| mem_wdata | output | 64 | Store data |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 64 | Load data, low-aligned |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Extended load result |
| wb_we | output | 1 | Base writeback enable |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Updated base address |
| flt_undef | output | 1 | Undefined-instruction pulse |
| flt_spalign | output | 1 | Stack-pointer alignment fault pulse |

## Verification
The destination write of a load and the base writeback of a pre- or post-index access fall in the same response cycle. The bench provokes this by sweeping every size, opc and class combination with base fields 4 and 31 and destination fields 4, 9 and 31. This covers the overlap case where base and destination share register 4. In the cycle the response is raised, the bench samples both ports together. It judges the pair against arithmetically computed extension and address sums, expecting exactly one write in the overlap case and none from the zero register. It also confirms that neither port fires in the response-wait cycle before the response.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

    localparam int XLEN     = 64;
    localparam int IW       = 32;
    localparam int RIDX_W   = 5;
    localparam int IMM9_W   = 9;
    localparam int IMM12_W  = 12;
    localparam int SIZE_W   = 2;
    localparam int NARROW_W = 32;
    localparam logic [RIDX_W-1:0] ZR_IDX = 5'd31;

    typedef enum logic [1:0] {
        AM_UOFF = 2'd0,
        AM_PRE  = 2'd1,
        AM_POST = 2'd2
    } amode_e;

    typedef struct packed {
        logic              undef;
        logic              is_load;
        logic              sext;
        logic              reg64;
        logic [SIZE_W-1:0] size;
        amode_e            amode;
        logic              wback;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rt;
        logic [XLEN-1:0]   offset;
    } dec_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_agu_pkg::*;
(
    input  logic [IW-1:0] ins_word,
    output dec_t          dec
);

    logic [SIZE_W-1:0] sz;
    logic [1:0]        opc;
    logic              fmt_ok;
    logic              cls_ok;
    logic              op_ok;

    always_comb begin
        sz     = ins_word[31:30];
        opc    = ins_word[23:22];
        fmt_ok = (ins_word[29:25] == 5'b11100);
        dec        = '0;
        dec.size   = sz;
        dec.rn     = ins_word[9:5];
        dec.rt     = ins_word[4:0];

        // addressing class and offset
        if (ins_word[24]) begin
            dec.amode  = AM_UOFF;
            dec.offset = {{(XLEN-IMM12_W){1'b0}}, ins_word[21:10]} << sz;
            dec.wback  = 1'b0;
            cls_ok     = 1'b1;
        end else begin
            dec.amode  = ins_word[11] ? AM_PRE : AM_POST;
            dec.offset = {{(XLEN-IMM9_W){ins_word[20]}}, ins_word[20:12]};
            dec.wback  = 1'b1;
            cls_ok     = !ins_word[21] && ins_word[10];
        end

        // operation kind and destination width
        if (!opc[1]) begin
            dec.is_load = opc[0];
            dec.sext    = 1'b0;
            dec.reg64   = (sz == 2'b11);
            op_ok       = 1'b1;
        end else begin
            dec.is_load = 1'b1;
            dec.sext    = 1'b1;
            dec.reg64   = !opc[0];
            op_ok       = (sz != 2'b11) && !((sz == 2'b10) && opc[0]);
        end

        dec.undef = !(fmt_ok && cls_ok && op_ok);

        // overlapping base/destination on a load: the loaded value wins
        if (dec.is_load && dec.wback && (dec.rn == dec.rt) && (dec.rn != ZR_IDX)) begin
            dec.wback = 1'b0;
        end
    end

endmodule

// File: rtl/ldst_addr.sv
module ldst_addr
    import ldst_agu_pkg::*;
#(
    parameter int SP_ALIGN_LG = 4
) (
    input  logic [RIDX_W-1:0] rn,
    input  amode_e            amode,
    input  logic [XLEN-1:0]   offset,
    input  logic [XLEN-1:0]   gpr_base,
    input  logic [XLEN-1:0]   sp_base,
    output logic [XLEN-1:0]   acc_addr,
    output logic [XLEN-1:0]   upd_addr,
    output logic              use_sp,
    output logic              sp_misalign
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] sum;

    always_comb begin
        use_sp      = (rn == ZR_IDX);
        base        = use_sp ? sp_base : gpr_base;
        sum         = base + offset;
        acc_addr    = (amode == AM_POST) ? base : sum;
        upd_addr    = sum;
        sp_misalign = use_sp && (|base[SP_ALIGN_LG-1:0]);
    end

endmodule

// File: rtl/ldst_extend.sv
module ldst_extend
    import ldst_agu_pkg::*;
(
    input  logic [SIZE_W-1:0] size,
    input  logic              sext,
    input  logic              reg64,
    input  logic [XLEN-1:0]   raw,
    output logic [XLEN-1:0]   res
);

    localparam int NSIZES = 1 << SIZE_W;

    logic [XLEN-1:0] cand [NSIZES];

    generate
        for (genvar g = 0; g < NSIZES; g++) begin : g_width
            localparam int W = 8 << g;
            if (W < XLEN) begin : g_part
                assign cand[g] = {{(XLEN-W){sext & raw[W-1]}}, raw[W-1:0]};
            end else begin : g_full
                assign cand[g] = raw;
            end
        end
    endgenerate

    always_comb begin
        res = cand[size];
        if (!reg64) begin
            res[XLEN-1:NARROW_W] = '0;
        end
    end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_agu_pkg::*;
#(
    parameter int SP_ALIGN_LG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [31:0]       ins_word,
    output logic              ins_ready,
    output logic [4:0]        base_idx,
    input  logic [63:0]       base_val,
    output logic [4:0]        src_idx,
    input  logic [63:0]       src_val,
    input  logic [63:0]       sp_val,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [63:0]       mem_addr,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              rd_we,
    output logic [4:0]        rd_idx,
    output logic [63:0]       rd_data,
    output logic              wb_we,
    output logic              wb_to_sp,
    output logic [4:0]        wb_idx,
    output logic [63:0]       wb_data,
    output logic              flt_undef,
    output logic              flt_spalign
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_RESP  = 2'd2,
        ST_FAULT = 2'd3
    } state_e;

    state_e state_q, state_d;

    dec_t              dec;
    logic [XLEN-1:0]   acc_addr, upd_addr, ext_res;
    logic              use_sp, sp_misalign, accept, reject;

    logic [XLEN-1:0]   addr_q, upd_q, wdata_q;
    logic              is_load_q, sext_q, reg64_q, wback_q, use_sp_q;
    logic              undef_q, spflt_q;
    logic [SIZE_W-1:0] size_q;
    logic [RIDX_W-1:0] rt_q, rn_q;
    amode_e            amode_q;

    ldst_decode u_dec (
        .ins_word (ins_word),
        .dec      (dec)
    );

    ldst_addr #(.SP_ALIGN_LG(SP_ALIGN_LG)) u_addr (
        .rn          (dec.rn),
        .amode       (dec.amode),
        .offset      (dec.offset),
        .gpr_base    (base_val),
        .sp_base     (sp_val),
        .acc_addr    (acc_addr),
        .upd_addr    (upd_addr),
        .use_sp      (use_sp),
        .sp_misalign (sp_misalign)
    );

    ldst_extend u_ext (
        .size  (size_q),
        .sext  (sext_q),
        .reg64 (reg64_q),
        .raw   (mem_rdata),
        .res   (ext_res)
    );

    assign base_idx = ins_word[9:5];
    assign src_idx  = ins_word[4:0];
    assign accept   = (state_q == ST_IDLE) && ins_valid;
    assign reject   = dec.undef || sp_misalign;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ins_valid) state_d = reject ? ST_FAULT : ST_REQ;  // T_ACCEPT / T_REJECT
            ST_REQ:   if (mem_gnt)    state_d = ST_RESP;                     // T_GRANT
            ST_RESP:  if (mem_rvalid) state_d = ST_IDLE;                     // T_RETIRE
            ST_FAULT: state_d = ST_IDLE;                                     // T_RECOVER
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // capture of the decoded access at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            upd_q     <= '0;
            wdata_q   <= '0;
            is_load_q <= 1'b0;
            sext_q    <= 1'b0;
            reg64_q   <= 1'b0;
            wback_q   <= 1'b0;
            use_sp_q  <= 1'b0;
            undef_q   <= 1'b0;
            spflt_q   <= 1'b0;
            size_q    <= '0;
            rt_q      <= '0;
            rn_q      <= '0;
            amode_q   <= AM_UOFF;
        end else if (accept) begin
            addr_q    <= acc_addr;
            upd_q     <= upd_addr;
            wdata_q   <= src_val;
            is_load_q <= dec.is_load;
            sext_q    <= dec.sext;
            reg64_q   <= dec.reg64;
            wback_q   <= dec.wback;
            use_sp_q  <= use_sp;
            undef_q   <= dec.undef;
            spflt_q   <= sp_misalign;
            size_q    <= dec.size;
            rt_q      <= dec.rt;
            rn_q      <= dec.rn;
            amode_q   <= dec.amode;
        end
    end

    // outputs
    always_comb begin
        ins_ready   = (state_q == ST_IDLE);
        mem_req     = (state_q == ST_REQ);
        mem_addr    = addr_q;
        mem_we      = !is_load_q;
        mem_size    = size_q;
        mem_wdata   = wdata_q;
        rd_we       = (state_q == ST_RESP) && mem_rvalid && is_load_q && (rt_q != ZR_IDX);
        rd_idx      = rt_q;
        rd_data     = ext_res;
        wb_we       = (state_q == ST_RESP) && mem_rvalid && wback_q;
        wb_to_sp    = use_sp_q;
        wb_idx      = rn_q;
        wb_data     = upd_q;
        flt_undef   = (state_q == ST_FAULT) && undef_q;
        flt_spalign = (state_q == ST_FAULT) && !undef_q && spflt_q;
    end

    AST_UOFF_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (amode_q != AM_UOFF)); // R1
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && !reg64_q) |-> (rd_data[63:32] == 32'h0)); // R5
    AST_FAULT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_undef || flt_spalign) |-> (!mem_req && !rd_we && !wb_we)); // R7
    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_undef || flt_spalign) |=> (!flt_undef && !flt_spalign)); // R7
    AST_OVERLAP_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we && wb_we) |-> (wb_to_sp || (wb_idx != rd_idx))); // R8
    AST_NO_ZR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_idx != ZR_IDX)); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_BUSY_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ins_ready); // R10
    AST_WRITES_ON_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || wb_we) |-> mem_rvalid); // R11

endmodule

// File: tb/ldst_agu_test.sv
module ldst_agu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_word = '0;
    logic        ins_ready;
    logic [4:0]  base_idx, src_idx;
    logic [63:0] base_val = '0, src_val = '0;
    logic [63:0] sp_val = 64'h0000_7FFF_FFF0_0000;
    logic        mem_req, mem_gnt = 1'b0, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        rd_we, wb_we, wb_to_sp, flt_undef, flt_spalign;
    logic [4:0]  rd_idx, wb_idx;
    logic [63:0] rd_data, wb_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ldst_agu uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
        .ins_ready(ins_ready), .base_idx(base_idx), .base_val(base_val),
        .src_idx(src_idx), .src_val(src_val), .sp_val(sp_val),
        .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .wb_we(wb_we), .wb_to_sp(wb_to_sp), .wb_idx(wb_idx), .wb_data(wb_data),
        .flt_undef(flt_undef), .flt_spalign(flt_spalign)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_u(input logic [1:0] sz, input logic [1:0] opc,
                                         input logic [11:0] imm, input logic [4:0] rn,
                                         input logic [4:0] rt);
        return {sz, 3'b111, 2'b00, 1'b1, opc, imm, rn, rt};
    endfunction

    function automatic logic [31:0] mk_i(input logic [1:0] sz, input logic [1:0] opc,
                                         input logic [8:0] imm, input logic pre,
                                         input logic [4:0] rn, input logic [4:0] rt);
        return {sz, 3'b111, 2'b00, 1'b0, opc, 1'b0, imm, pre, 1'b1, rn, rt};
    endfunction

    task automatic run(input logic [31:0] w, input logic [63:0] gbase, input logic [63:0] stv,
                       input int gdly, input logic [63:0] rdat);
        logic [1:0]  sz, opc;
        logic [4:0]  rn, rt;
        logic        u, pre, undef, misal, ld, sgn, r64, wb;
        logic [63:0] base, off, ea, nb, ev;
        string       ct;
        sz  = w[31:30]; opc = w[23:22]; rn = w[9:5]; rt = w[4:0];
        u   = w[24];    pre = w[11];
        undef = (w[29:25] != 5'b11100) || (!u && (w[21] || !w[10])) ||
                (opc[1] && ((sz == 2'b11) || ((sz == 2'b10) && opc[0])));
        base  = (rn == 5'd31) ? sp_val : gbase;
        off   = u ? ({52'b0, w[21:10]} << sz) : {{55{w[20]}}, w[20:12]};
        nb    = base + off;
        ea    = (u || pre) ? nb : base;
        misal = (rn == 5'd31) && (base[3:0] != 4'h0);
        ld    = (opc != 2'b00);
        sgn   = opc[1];
        r64   = opc[1] ? !opc[0] : (sz == 2'b11);
        wb    = !u && !(ld && (rn == rt) && (rn != 5'd31));
        ct    = u ? "R1" : (pre ? "R2" : "R3");
        unique case (sz)
            2'd0: ev = sgn ? {{56{rdat[7]}},  rdat[7:0]}  : {56'b0, rdat[7:0]};
            2'd1: ev = sgn ? {{48{rdat[15]}}, rdat[15:0]} : {48'b0, rdat[15:0]};
            2'd2: ev = sgn ? {{32{rdat[31]}}, rdat[31:0]} : {32'b0, rdat[31:0]};
            default: ev = rdat;
        endcase
        if (!r64) ev[63:32] = 32'h0;

        @(negedge clk);
        ins_word = w; ins_valid = 1'b1; base_val = gbase; src_val = stv;
        @(posedge clk);
        #1 ins_valid = 1'b0; ins_word = ~w; base_val = ~gbase; src_val = ~stv;
        @(negedge clk);
        if (undef || misal) begin
            chk("R7 undef pulse", {63'b0, flt_undef}, {63'b0, undef});
            chk("R4 align pulse", {63'b0, flt_spalign}, {63'b0, !undef && misal});
            chk("R7 no request on fault", {63'b0, mem_req}, 64'd0);
            @(negedge clk);
            chk("R7 pulse ends", {62'b0, flt_undef, flt_spalign}, 64'd0);
            chk("R10 ready after fault", {63'b0, ins_ready}, 64'd1);
            return;
        end
        chk("R10 busy after accept", {63'b0, ins_ready}, 64'd0);
        for (int i = 0; i < gdly; i++) begin
            chk("R10 request held", {63'b0, mem_req}, 64'd1);
            chk({ct, " address while waiting"}, mem_addr, ea);
            @(negedge clk);
        end
        mem_gnt = 1'b1;
        #1;
        chk("R10 request up", {63'b0, mem_req}, 64'd1);
        chk({ct, " R4 access address"}, mem_addr, ea);
        chk("R6 write flag", {63'b0, mem_we}, {63'b0, !ld});
        chk("R6 access size", {62'b0, mem_size}, {62'b0, sz});
        if (!ld) chk("R6 R8 store data", mem_wdata, stv);
        @(negedge clk);
        mem_gnt = 1'b0;
        #1;
        chk("R10 request dropped", {63'b0, mem_req}, 64'd0);
        chk("R11 no writes before response", {62'b0, rd_we, wb_we}, 64'd0);
        mem_rvalid = 1'b1; mem_rdata = rdat;
        #1;
        chk("R9 R11 destination write", {63'b0, rd_we}, {63'b0, ld && (rt != 5'd31)});
        if (ld && (rt != 5'd31)) begin
            chk("R11 destination index", {59'b0, rd_idx}, {59'b0, rt});
            chk(sgn ? "R5 extended data" : "R6 extended data", rd_data, ev);
        end
        chk("R1 R8 R11 base write", {63'b0, wb_we}, {63'b0, wb});
        if (wb) begin
            chk({ct, " written-back base"}, wb_data, nb);
            chk("R4 writeback target", {63'b0, wb_to_sp}, {63'b0, rn == 5'd31});
            if (rn != 5'd31) chk("R11 writeback index", {59'b0, wb_idx}, {59'b0, rn});
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        chk("R10 ready after response", {63'b0, ins_ready}, 64'd1);
        chk("R11 writes end", {62'b0, rd_we, wb_we}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0]  i9 [4];
        logic [11:0] i12 [4];
        logic [4:0]  rns [2];
        logic [4:0]  rts [3];
        int k;
        i9  = '{9'h100, 9'h0FF, 9'h1FF, 9'h005};
        i12 = '{12'hFFF, 12'h000, 12'h001, 12'h155};
        rns = '{5'd4, 5'd31};
        rts = '{5'd4, 5'd9, 5'd31};
        k = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset ready", {63'b0, ins_ready}, 64'd1);
        chk("R10 reset idle outputs", {59'b0, mem_req, rd_we, wb_we, flt_undef, flt_spalign}, 64'd0);
        rst_n = 1'b1;

        for (int sz = 0; sz < 4; sz++)
            for (int opc = 0; opc < 4; opc++)
                for (int cls = 0; cls < 3; cls++)
                    for (int a = 0; a < 2; a++)
                        for (int b = 0; b < 3; b++) begin
                            logic [31:0] w;
                            logic [63:0] rd;
                            rd = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15);
                            if (cls == 0)
                                w = mk_u(sz[1:0], opc[1:0], i12[k % 4], rns[a], rts[b]);
                            else
                                w = mk_i(sz[1:0], opc[1:0], i9[k % 4], cls == 1, rns[a], rts[b]);
                            run(w, 64'h0000_1234_5678_9A00 + 64'(k * 24), 64'hCAFE_0000_BEEF_0000 + 64'(k),
                                k % 3, rd);
                            k++;
                        end

        // class-field and format faults (R7)
        run(mk_i(2'd1, 2'd3, 9'h010, 1'b1, 5'd2, 5'd3) & ~32'h0000_0400, 64'h1000, 64'h0, 0, 64'h0);
        run(mk_i(2'd1, 2'd3, 9'h010, 1'b0, 5'd2, 5'd3) | 32'h0020_0000, 64'h1000, 64'h0, 0, 64'h0);
        run(mk_u(2'd1, 2'd1, 12'h004, 5'd2, 5'd3) | 32'h0400_0000, 64'h1000, 64'h0, 0, 64'h0);

        // misaligned stack pointer (R4), then a legal access after it
        sp_val = 64'h0000_7FFF_FFF0_0008;
        run(mk_i(2'd1, 2'd2, 9'h1F0, 1'b1, 5'd31, 5'd6), 64'h0, 64'h0, 0, 64'h0);
        run(mk_u(2'd3, 2'd0, 12'h002, 5'd31, 5'd7), 64'h0, 64'h55, 1, 64'h0);
        sp_val = 64'h0000_7FFF_FFF0_0000;
        run(mk_i(2'd1, 2'd2, 9'h1F0, 1'b0, 5'd31, 5'd6), 64'h0, 64'h0, 2, 64'h0000_0000_0000_8001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule